// File: doc/BRIEF.md
# Low-Power Mode Clock Enable Controller

This block holds the power-mode bits of a processor status word and turns them into enable levels for the clock tree and oscillators. There are six enables: CPU/main clock, sub-main clock, auxiliary clock, DCO oscillator, DCO DC generator and crystal oscillator. Software writes the status word to move between active mode and the sleep levels. The enables follow the registered mode bits combinationally, so they change in the cycle after the write.

The block also models interrupt entry and return. An accepted interrupt saves the status word into a one-deep stack and clears the wake bits in the live word, so the system runs while the handler executes. A return strobe restores the saved word. If the handler did not change the saved copy, the old sleep level resumes. A handler that writes the saved copy through the stack port, for example to clear the CPU-off bit, makes the return leave the system awake instead.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word and the saved copy are zero and all six enables are 1.
- R2: A status write (`sr_wr_en`) loads `sr_wr_data` into `sr_q` on the next edge, unless an interrupt is granted or a return is strobed in the same cycle.
- R3: Bit layout: GIE is bit 3, CPUOFF bit 4, OSCOFF bit 5, SCG0 bit 6, SCG1 bit 7. `mclk_en` is 0 exactly when CPUOFF is 1.
- R4: `smclk_en` and `dco_osc_en` are 0 exactly when SCG1 or OSCOFF is 1.
- R5: `dco_dc_en` is 0 when any of these holds: OSCOFF is 1; SCG1 and SCG0 are both 1; SCG0 is 1 while `dco_feeds_smclk` is 0. Otherwise it is 1.
- R6: `aclk_en` and `xtal_en` are 0 exactly when OSCOFF is 1, whatever SCG0 and SCG1 are.
- R7: `irq_grant` is 1 exactly when `irq_req` is 1, GIE is 1, and either OSCOFF is 0 or `irq_ext` is 1.
- R8: On a grant, the saved copy takes the current status word, and the live word clears GIE, CPUOFF, OSCOFF and SCG1 while keeping every other bit. A grant overrides a status write, a return and a stack write in the same cycle.
- R9: A return strobe without a grant loads the saved copy into the status word. This takes priority over a status write in the same cycle.
- R10: A stack write without a grant loads `stk_wr_data` into the saved copy, visible on `stk_rd_data` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | SR_W | Status word write value |
| irq_req | input | 1 | Interrupt request offered for acceptance |
| irq_ext | input | 1 | Request comes from an external source |
| reti | input | 1 | Return-from-interrupt strobe |
| stk_wr_en | input | 1 | Saved-copy write strobe |
| stk_wr_data | input | SR_W | Saved-copy write value |
| dco_feeds_smclk | input | 1 | DCO is the source of the sub-main clock |
| sr_q | output | SR_W | Live status word |
| stk_rd_data | output | SR_W | Saved status word |
| irq_grant | output | 1 | Interrupt accepted this cycle |
| mclk_en | output | 1 | CPU/main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dco_osc_en | output | 1 | DCO oscillator enable |
| dco_dc_en | output | 1 | DCO DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
The live word and the saved word are both visible at the ports. A wrong save, clear or restore therefore shows on `sr_q` or `stk_rd_data` one edge after the grant or return that caused it. The enables and `irq_grant` are combinational from the live word, so a decode fault shows in the same cycle as the word that exposes it. A priority fault between simultaneous strobes shows on the next edge. Random cycles with frequent requests and returns reach the sleep levels under interrupt traffic. Directed sequences cover the sleep-again and stay-awake handler paths.

// File: rtl/lpm_pkg.sv
// Shared definitions for the low-power clock enable controller.
// Assumes a status word of at least 8 bits.
package lpm_pkg;
    localparam int GIE_B    = 3;
    localparam int CPUOFF_B = 4;
    localparam int OSCOFF_B = 5;
    localparam int SCG0_B   = 6;
    localparam int SCG1_B   = 7;

    typedef struct packed {
        logic mclk;
        logic smclk;
        logic aclk;
        logic dco_osc;
        logic dco_dc;
        logic xtal;
    } clk_en_t;
endpackage

// File: rtl/lpm_sr_ctrl.sv
// Holds the live status word and its one-deep saved copy, and decides
// interrupt acceptance. Priority per cycle: grant, then return, then
// status write. Assumes at most one nesting level.
module lpm_sr_ctrl
    import lpm_pkg::*;
#(
    parameter int SR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_wr_en,
    input  logic [SR_W-1:0] sr_wr_data,
    input  logic            irq_req,
    input  logic            irq_ext,
    input  logic            reti,
    input  logic            stk_wr_en,
    input  logic [SR_W-1:0] stk_wr_data,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] stk_q,
    output logic            irq_grant
);
    localparam logic [SR_W-1:0] ONE       = {{(SR_W-1){1'b0}}, 1'b1};
    localparam logic [SR_W-1:0] ENTRY_CLR = (ONE << GIE_B) | (ONE << CPUOFF_B)
                                          | (ONE << OSCOFF_B) | (ONE << SCG1_B);

    // Acceptance: interrupts enabled, and only external sources when the oscillator is off
    always_comb begin
        irq_grant = irq_req && sr_q[GIE_B] && (!sr_q[OSCOFF_B] || irq_ext);
    end

    // Live status word: clear wake bits on entry, restore on return, else software write
    always_ff @(posedge clk) begin
        if (!rst_n)          sr_q <= '0;
        else if (irq_grant)  sr_q <= sr_q & ~ENTRY_CLR;
        else if (reti)       sr_q <= stk_q;
        else if (sr_wr_en)   sr_q <= sr_wr_data;
    end

    // Saved copy: capture on entry, otherwise writable by the handler
    always_ff @(posedge clk) begin
        if (!rst_n)          stk_q <= '0;
        else if (irq_grant)  stk_q <= sr_q;
        else if (stk_wr_en)  stk_q <= stk_wr_data;
    end
endmodule

// File: rtl/lpm_clk_decode.sv
// Maps the four mode bits to clock and oscillator enables. Purely
// combinational; assumes the mode bits come from a register.
module lpm_clk_decode
    import lpm_pkg::*;
(
    input  logic    cpuoff,
    input  logic    oscoff,
    input  logic    scg0,
    input  logic    scg1,
    input  logic    dco_feeds_smclk,
    output clk_en_t en
);
    logic smclk_stop;
    logic dc_stop;

    // Enable decode for every clock and oscillator
    always_comb begin
        smclk_stop = scg1 || oscoff;
        dc_stop    = oscoff || (scg1 && scg0) || (scg0 && !dco_feeds_smclk);
        en.mclk    = !cpuoff;
        en.smclk   = !smclk_stop;
        en.dco_osc = !smclk_stop;
        en.dco_dc  = !dc_stop;
        en.aclk    = !oscoff;
        en.xtal    = !oscoff;
    end
endmodule

// File: rtl/lpm_clk_ctrl.sv
// Top of the low-power clock enable controller: status word with
// interrupt save/restore, and the enable decode driven from it.
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int SR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sr_wr_en,
    input  logic [SR_W-1:0] sr_wr_data,
    input  logic            irq_req,
    input  logic            irq_ext,
    input  logic            reti,
    input  logic            stk_wr_en,
    input  logic [SR_W-1:0] stk_wr_data,
    input  logic            dco_feeds_smclk,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] stk_rd_data,
    output logic            irq_grant,
    output logic            mclk_en,
    output logic            smclk_en,
    output logic            aclk_en,
    output logic            dco_osc_en,
    output logic            dco_dc_en,
    output logic            xtal_en
);
    clk_en_t en;

    lpm_sr_ctrl #(.SR_W(SR_W)) u_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_wr_en    (sr_wr_en),
        .sr_wr_data  (sr_wr_data),
        .irq_req     (irq_req),
        .irq_ext     (irq_ext),
        .reti        (reti),
        .stk_wr_en   (stk_wr_en),
        .stk_wr_data (stk_wr_data),
        .sr_q        (sr_q),
        .stk_q       (stk_rd_data),
        .irq_grant   (irq_grant)
    );

    lpm_clk_decode u_dec (
        .cpuoff          (sr_q[CPUOFF_B]),
        .oscoff          (sr_q[OSCOFF_B]),
        .scg0            (sr_q[SCG0_B]),
        .scg1            (sr_q[SCG1_B]),
        .dco_feeds_smclk (dco_feeds_smclk),
        .en              (en)
    );

    // Flatten the enable struct onto the ports
    always_comb begin
        mclk_en    = en.mclk;
        smclk_en   = en.smclk;
        aclk_en    = en.aclk;
        dco_osc_en = en.dco_osc;
        dco_dc_en  = en.dco_dc;
        xtal_en    = en.xtal;
    end
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
// Checker for lpm_clk_ctrl: relates strobes to the registered words and
// the words to the enables. Bound to every instance of the top.
module lpm_clk_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int SR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sr_wr_en,
    input logic [SR_W-1:0] sr_wr_data,
    input logic            irq_ext,
    input logic            reti,
    input logic [SR_W-1:0] sr_q,
    input logic [SR_W-1:0] stk_rd_data,
    input logic            irq_grant,
    input logic            mclk_en,
    input logic            aclk_en,
    input logic            xtal_en
);
    // R2
    sr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !irq_grant && !reti) |=> sr_q == $past(sr_wr_data));

    // R3
    mclk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en != sr_q[CPUOFF_B]);

    // R6
    osc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aclk_en == xtal_en) && (aclk_en != sr_q[OSCOFF_B]));

    // R7
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |-> (sr_q[GIE_B] && (!sr_q[OSCOFF_B] || irq_ext)));

    // R8
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |=> stk_rd_data == $past(sr_q));

    // R8
    entry_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grant |=> (!sr_q[GIE_B] && !sr_q[CPUOFF_B] && !sr_q[OSCOFF_B]
                       && !sr_q[SCG1_B] && sr_q[SCG0_B] == $past(sr_q[SCG0_B])));

    // R9
    return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !irq_grant) |=> sr_q == $past(stk_rd_data));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.SR_W(SR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sr_wr_en    (sr_wr_en),
    .sr_wr_data  (sr_wr_data),
    .irq_ext     (irq_ext),
    .reti        (reti),
    .sr_q        (sr_q),
    .stk_rd_data (stk_rd_data),
    .irq_grant   (irq_grant),
    .mclk_en     (mclk_en),
    .aclk_en     (aclk_en),
    .xtal_en     (xtal_en)
);

// File: tb/tb_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_clk_ctrl;
    localparam int SR_W = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sr_wr_en, irq_req, irq_ext, reti, stk_wr_en, dco_feeds_smclk;
    logic [SR_W-1:0] sr_wr_data, stk_wr_data;
    logic [SR_W-1:0] sr_q, stk_rd_data;
    logic            irq_grant, mclk_en, smclk_en, aclk_en, dco_osc_en, dco_dc_en, xtal_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [SR_W-1:0] ref_sr, ref_stk;

    always #4 clk = ~clk;

    lpm_clk_ctrl #(.SR_W(SR_W)) dut (
        .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .irq_req(irq_req), .irq_ext(irq_ext), .reti(reti), .stk_wr_en(stk_wr_en),
        .stk_wr_data(stk_wr_data), .dco_feeds_smclk(dco_feeds_smclk),
        .sr_q(sr_q), .stk_rd_data(stk_rd_data), .irq_grant(irq_grant),
        .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
        .dco_osc_en(dco_osc_en), .dco_dc_en(dco_dc_en), .xtal_en(xtal_en)
    );

    // Expected enables {mclk, smclk, aclk, dco_osc, dco_dc, xtal} per R3..R6
    function automatic logic [5:0] exp_en(input logic [SR_W-1:0] s, input logic dsel);
        logic c, o, z0, z1;
        c = s[4]; o = s[5]; z0 = s[6]; z1 = s[7];
        return {!c, !(z1 || o), !o, !(z1 || o),
                !(o || (z1 && z0) || (z0 && !dsel)), !o};
    endfunction

    // Expected grant per R7
    function automatic logic exp_grant(input logic [SR_W-1:0] s, input logic rq, input logic ex);
        return rq && s[3] && (!s[5] || ex);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check settled outputs, advance the model
    task automatic cycle(input logic wr, input logic [SR_W-1:0] wd, input logic rq,
                         input logic ex, input logic rt, input logic sw,
                         input logic [SR_W-1:0] sd, input logic ds);
        logic g;
        logic [SR_W-1:0] nsr, nstk;
        @(negedge clk);
        sr_wr_en = wr; sr_wr_data = wd; irq_req = rq; irq_ext = ex;
        reti = rt; stk_wr_en = sw; stk_wr_data = sd; dco_feeds_smclk = ds;
        #1;
        check("R2 R8 R9 status word", 32'(sr_q), 32'(ref_sr));
        check("R8 R10 saved word", 32'(stk_rd_data), 32'(ref_stk));
        check("R3 R4 R5 R6 enables",
              32'({mclk_en, smclk_en, aclk_en, dco_osc_en, dco_dc_en, xtal_en}),
              32'(exp_en(ref_sr, ds)));
        g = exp_grant(ref_sr, rq, ex);
        check("R7 grant", 32'(irq_grant), 32'(g));
        nsr = ref_sr; nstk = ref_stk;
        if (g) begin
            nstk = ref_sr;
            nsr  = ref_sr & ~16'h00B8;
        end else begin
            if (rt)      nsr = ref_stk;
            else if (wr) nsr = wd;
            if (sw)      nstk = sd;
        end
        ref_sr = nsr; ref_stk = nstk;
    endtask

    task automatic idle(input logic ds);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, ds);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0;
        sr_wr_en = 0; sr_wr_data = '0; irq_req = 0; irq_ext = 0; reti = 0;
        stk_wr_en = 0; stk_wr_data = '0; dco_feeds_smclk = 1;
        ref_sr = '0; ref_stk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, all enables on
        idle(1'b1);
        check("R1 reset enables all on",
              32'({mclk_en, smclk_en, aclk_en, dco_osc_en, dco_dc_en, xtal_en}), 32'h3F);

        // R3..R6: each sleep level, both DCO source settings
        for (int lv = 0; lv < 5; lv++) begin
            logic [SR_W-1:0] v;
            case (lv)
                0: v = 16'h0018;
                1: v = 16'h0058;
                2: v = 16'h0098;
                3: v = 16'h00D8;
                default: v = 16'h00F8;
            endcase
            cycle(1'b1, v, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
            idle(1'b1);
            idle(1'b0);
        end

        // R7: in the deepest level a non-external request is refused
        cycle(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        // R7 R8: external request wakes; SCG0 kept
        cycle(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
        idle(1'b1);
        check("R8 woken CPU clock", 32'(mclk_en), 32'd1);
        // R9: unmodified return goes back to sleep
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b1);
        idle(1'b1);
        check("R9 sleep resumes", 32'(aclk_en), 32'd0);

        // R10 R9: handler clears CPUOFF in the saved copy, return stays awake
        cycle(1'b1, 16'h00D8, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0008, 1'b1);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b1);
        idle(1'b1);
        check("R9 R10 stays awake", 32'(mclk_en & smclk_en), 32'd1);

        // R8: grant beats a status write, return and stack write together
        cycle(1'b1, 16'h0098, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        cycle(1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234, 1'b1);
        // R9: return beats a status write
        cycle(1'b1, 16'h00F8, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b1);
        idle(1'b1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] & r[1], 16'($urandom) | {12'h0, r[2], 3'b000},
                  r[3] | r[4], r[5], r[6] & r[7], r[8] & r[9],
                  16'($urandom), r[10]);
        end

        idle(1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule